// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block divides a fast reference clock by an integer ratio and produces the result as a clock-enable waveform, one bit per reference cycle. The division is not set by a single terminal count. It is set by two lengths: a high duration and a low duration. Two flags go with them: one marks odd ratios, and one bypasses the counters so that every reference cycle is enabled.

The block can be configured in two ways. In ratio mode it takes a plain divide ratio, clamps it into the supported range and encodes it into the two packed configuration words. Those words also appear on output ports, so software-facing logic can store them. In packed mode it takes the two configuration words directly. In both modes the active setting is decoded back into an effective ratio and reported. A new setting is accepted only at a period boundary, so a change never cuts a high or low phase short.

Top module: `hl_clkdiv`

## Requirements
- R1: The encoder places high = floor(r/2) in word A bits 11:6 and low = r - high in word A bits 5:0, where r is the clamped ratio; all other bits of word A are 0.
- R2: In word B, bit 7 is r modulo 2 and bit 6 is 1 exactly when r equals 1; all other bits of word B are 0.
- R3: A ratio input of 0 is treated as 1, and a ratio input above 128 is treated as 128, in both the encoded words and the waveform.
- R4: Outside bypass, clk_en_o is 1 for high-length reference cycles and then 0 for low-length cycles, repeating, with each period starting on its high phase.
- R5: A high or low field value of 0 stands for a length of 64 cycles. A field value f from 1 to 63 stands for f cycles.
- R6: When the no-count flag (word B bit 6) is active, clk_en_o is 1 on every reference cycle. The high and low fields have no effect in that case.
- R7: A configuration change takes effect only at the start of the next high phase; the period in progress completes with its old lengths.
- R8: ratio_o reports the active ratio: 1 in bypass, otherwise the high length plus the low length. It changes in the same cycle that the new period starts.
- R9: While rst_n is low, clk_en_o is 0 and ratio_o is 1. The first rising edge after reset loads the configuration presented at that edge.
- R10: cfg_mode_i = 0 selects the ratio input and cfg_mode_i = 1 selects word_a_i/word_b_i. The edge flag (word B bit 7) has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 1 | 0: use ratio_i, 1: use packed words |
| ratio_i | input | 8 | Requested divide ratio (clamped to 1..128) |
| word_a_i | input | 16 | Packed lengths: low in 5:0, high in 11:6 |
| word_b_i | input | 16 | Packed flags: no-count in bit 6, edge in bit 7 |
| clk_en_o | output | 1 | Divided clock-enable waveform |
| ratio_o | output | 8 | Effective ratio of the active configuration |
| enc_word_a_o | output | 16 | Word A encoded from ratio_i |
| enc_word_b_o | output | 16 | Word B encoded from ratio_i |

## Verification
The bench builds the block with its default 6-bit field width. This gives 16-bit words, ratios up to 128 and an 8-bit ratio port, so over-range requests up to 255 can be driven. With this width, the zero-means-64 rule is reached both through encoded ratios 127 and 128 and through all-zero packed fields. A behavioural queue model predicts every enable bit and the reported ratio for bypass, odd and even ratios, mid-period reconfiguration and mode switches.

// File: rtl/hlcd_pkg.sv
package hlcd_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/hlcd_encode.sv
module hlcd_encode #(
    parameter int FIELD_W = 6,
    parameter int RATIO_W = FIELD_W + 2,
    parameter int WORD_W  = 16
) (
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [WORD_W-1:0]  word_a_o,
    output logic [WORD_W-1:0]  word_b_o
);
    localparam int MAX_RATIO = 2 ** (FIELD_W + 1);

    logic [RATIO_W-1:0] r_c;
    logic [RATIO_W-1:0] hi_c;
    logic [RATIO_W-1:0] lo_c;

    always_comb begin
        r_c = ratio_i;
        if (ratio_i == '0) begin
            r_c = RATIO_W'(1);
        end else if (ratio_i > RATIO_W'(MAX_RATIO)) begin
            r_c = RATIO_W'(MAX_RATIO);
        end
        hi_c = r_c >> 1;
        lo_c = r_c - hi_c;

        word_a_o = '0;
        word_a_o[FIELD_W-1:0]         = lo_c[FIELD_W-1:0];
        word_a_o[2*FIELD_W-1:FIELD_W] = hi_c[FIELD_W-1:0];

        word_b_o = '0;
        word_b_o[FIELD_W+1] = r_c[0];
        word_b_o[FIELD_W]   = (r_c == RATIO_W'(1));
    end

    logic unused_bits;
    assign unused_bits = ^{hi_c[RATIO_W-1:FIELD_W], lo_c[RATIO_W-1:FIELD_W]};
endmodule

// File: rtl/hlcd_decode.sv
module hlcd_decode #(
    parameter int FIELD_W = 6,
    parameter int WORD_W  = 16,
    parameter int LEN_W   = FIELD_W + 1
) (
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    output logic [LEN_W-1:0]  hi_len_o,
    output logic [LEN_W-1:0]  lo_len_o,
    output logic              byp_o
);
    logic [FIELD_W-1:0] lo_f;
    logic [FIELD_W-1:0] hi_f;

    assign lo_f = word_a_i[FIELD_W-1:0];
    assign hi_f = word_a_i[2*FIELD_W-1:FIELD_W];

    // zero field stands for the full 2**FIELD_W length
    assign lo_len_o = (lo_f == '0) ? {1'b1, {FIELD_W{1'b0}}} : {1'b0, lo_f};
    assign hi_len_o = (hi_f == '0) ? {1'b1, {FIELD_W{1'b0}}} : {1'b0, hi_f};
    assign byp_o    = word_b_i[FIELD_W];

    logic unused_fields;
    assign unused_fields = ^{word_a_i[WORD_W-1:2*FIELD_W],
                             word_b_i[WORD_W-1:FIELD_W+1],
                             word_b_i[FIELD_W-1:0]};
endmodule

// File: rtl/hlcd_wave.sv
module hlcd_wave
    import hlcd_pkg::*;
#(
    parameter int FIELD_W = 6,
    parameter int LEN_W   = FIELD_W + 1,
    parameter int RATIO_W = FIELD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEN_W-1:0]   hi_len_i,
    input  logic [LEN_W-1:0]   lo_len_i,
    input  logic               byp_i,
    output logic               clk_en_o,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam int MAX_RATIO = 2 ** (FIELD_W + 1);

    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] hi;
        logic [LEN_W-1:0] lo;
        logic             byp;
        logic             out;
    } wave_st_t;

    wave_st_t st_d;
    wave_st_t st_q;
    logic     boundary;

    always_comb begin
        st_d     = st_q;
        boundary = st_q.byp || (st_q.ph == PH_LOW && st_q.cnt == LEN_W'(1));
        if (boundary) begin
            st_d.hi  = hi_len_i;
            st_d.lo  = lo_len_i;
            st_d.byp = byp_i;
            st_d.ph  = PH_HIGH;
            st_d.cnt = hi_len_i;
            st_d.out = 1'b1;
        end else if (st_q.ph == PH_HIGH) begin
            if (st_q.cnt == LEN_W'(1)) begin
                st_d.ph  = PH_LOW;
                st_d.cnt = st_q.lo;
                st_d.out = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - LEN_W'(1);
                st_d.out = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_LOW, cnt: LEN_W'(1), hi: LEN_W'(1), lo: LEN_W'(1),
                      byp: 1'b1, out: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_en_o = st_q.out;
    assign ratio_o  = st_q.byp ? RATIO_W'(1)
                               : ({1'b0, st_q.hi} + {1'b0, st_q.lo});

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(st_q.hi) && $stable(st_q.lo) && $stable(st_q.byp))); // R7
    AST_BYPASS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && byp_i) |=> clk_en_o); // R6
    AST_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HIGH && st_q.cnt == LEN_W'(1) && !st_q.byp) |=> !clk_en_o); // R4
    AST_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_LOW) |-> !clk_en_o); // R4
    AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_o >= RATIO_W'(1)) && (ratio_o <= RATIO_W'(MAX_RATIO))); // R8
endmodule

// File: rtl/hl_clkdiv.sv
module hl_clkdiv #(
    parameter int FIELD_W = 6,
    parameter int WORD_W  = 16,
    parameter int RATIO_W = FIELD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_mode_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [WORD_W-1:0]  word_a_i,
    input  logic [WORD_W-1:0]  word_b_i,
    output logic               clk_en_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [WORD_W-1:0]  enc_word_a_o,
    output logic [WORD_W-1:0]  enc_word_b_o
);
    localparam int LEN_W     = FIELD_W + 1;
    localparam int MAX_RATIO = 2 ** (FIELD_W + 1);

    logic [WORD_W-1:0] sel_a;
    logic [WORD_W-1:0] sel_b;
    logic [LEN_W-1:0]  hi_len;
    logic [LEN_W-1:0]  lo_len;
    logic              byp;

    hlcd_encode #(.FIELD_W(FIELD_W), .RATIO_W(RATIO_W), .WORD_W(WORD_W)) i_encode (
        .ratio_i  (ratio_i),
        .word_a_o (enc_word_a_o),
        .word_b_o (enc_word_b_o)
    );

    assign sel_a = cfg_mode_i ? word_a_i : enc_word_a_o;
    assign sel_b = cfg_mode_i ? word_b_i : enc_word_b_o;

    hlcd_decode #(.FIELD_W(FIELD_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) i_decode (
        .word_a_i (sel_a),
        .word_b_i (sel_b),
        .hi_len_o (hi_len),
        .lo_len_o (lo_len),
        .byp_o    (byp)
    );

    hlcd_wave #(.FIELD_W(FIELD_W), .LEN_W(LEN_W), .RATIO_W(RATIO_W)) i_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_len_i (hi_len),
        .lo_len_i (lo_len),
        .byp_i    (byp),
        .clk_en_o (clk_en_o),
        .ratio_o  (ratio_o)
    );

    AST_ENC_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode_i && ratio_i >= RATIO_W'(2) && ratio_i <= RATIO_W'(MAX_RATIO))
        |-> (({1'b0, hi_len} + {1'b0, lo_len}) == ratio_i && !byp)); // R1
    AST_ZERO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode_i && ratio_i == '0) |-> byp); // R3
endmodule

// File: tb/test_hl_clkdiv.sv
module test_hl_clkdiv;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_mode_i;
    logic [7:0]  ratio_i;
    logic [15:0] word_a_i;
    logic [15:0] word_b_i;
    logic        clk_en_o;
    logic [7:0]  ratio_o;
    logic [15:0] enc_word_a_o;
    logic [15:0] enc_word_b_o;

    int    total = 0;
    int    bad = 0;
    bit    comparing = 0;
    bit    finished = 0;
    string tag = "R4";

    bit    q[$];
    logic  exp_out;
    int    exp_ratio;

    always #10 clk = ~clk;

    hl_clkdiv i_hl_clkdiv (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode_i   (cfg_mode_i),
        .ratio_i      (ratio_i),
        .word_a_i     (word_a_i),
        .word_b_i     (word_b_i),
        .clk_en_o     (clk_en_o),
        .ratio_o      (ratio_o),
        .enc_word_a_o (enc_word_a_o),
        .enc_word_b_o (enc_word_b_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model: a new period is queued bit by bit whenever the previous one is used up
    task automatic refill();
        int  r, hi, lo;
        bit  byp;
        if (!cfg_mode_i) begin
            r = int'(ratio_i);
            if (r < 1) r = 1;
            if (r > 128) r = 128;
            byp = (r == 1);
            hi = r / 2;
            lo = r - hi;
        end else begin
            lo  = (word_a_i[5:0] == 6'd0) ? 64 : int'(word_a_i[5:0]);
            hi  = (word_a_i[11:6] == 6'd0) ? 64 : int'(word_a_i[11:6]);
            byp = word_b_i[6];
        end
        if (byp) begin
            q.push_back(1'b1);
            exp_ratio = 1;
        end else begin
            for (int i = 0; i < hi; i++) q.push_back(1'b1);
            for (int i = 0; i < lo; i++) q.push_back(1'b0);
            exp_ratio = hi + lo;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            exp_out   = 1'b0;
            exp_ratio = 1;
        end else begin
            if (q.size() == 0) refill();
            exp_out = q.pop_front();
        end
    end

    always @(negedge clk) begin
        if (comparing && rst_n) begin
            check({tag, " clk_en_o"}, int'(clk_en_o), int'(exp_out));
            check("R8 ratio_o", int'(ratio_o), exp_ratio);
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ratio(input int r, input string t);
        @(negedge clk);
        cfg_mode_i = 1'b0;
        ratio_i    = 8'(r);
        tag        = t;
    endtask

    task automatic set_words(input int a, input int b, input string t);
        @(negedge clk);
        cfg_mode_i = 1'b1;
        word_a_i   = 16'(a);
        word_b_i   = 16'(b);
        tag        = t;
    endtask

    task automatic enc_check(input int r, input string t);
        int cl, hi, lo, ea, eb;
        cl = (r < 1) ? 1 : ((r > 128) ? 128 : r);
        hi = cl / 2;
        lo = cl - hi;
        ea = ((hi % 64) << 6) | (lo % 64);
        eb = ((cl % 2) << 7) | ((cl == 1 ? 1 : 0) << 6);
        ratio_i = 8'(r);
        #1;
        check({t, " enc_word_a_o"}, int'(enc_word_a_o), ea);
        check({t, " enc_word_b_o"}, int'(enc_word_b_o), eb);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        cfg_mode_i = 1'b0;
        ratio_i    = 8'd5;
        word_a_i   = '0;
        word_b_i   = '0;
        run(3);
        check("R9 reset clk_en_o", int'(clk_en_o), 0);
        check("R9 reset ratio_o", int'(ratio_o), 1);

        // encoder corners, combinational
        enc_check(5, "R1");
        enc_check(2, "R1");
        enc_check(127, "R1 R5");
        enc_check(128, "R1 R5");
        enc_check(1, "R2");
        enc_check(0, "R3");
        enc_check(200, "R3");
        enc_check(255, "R3");
        ratio_i = 8'd5;

        @(negedge clk);
        rst_n     = 1'b1;
        comparing = 1'b1;
        tag       = "R9";
        run(20);

        set_ratio(2, "R4");   run(12);
        set_ratio(3, "R4");   run(15);
        set_ratio(1, "R6");   run(8);
        set_ratio(7, "R4");   run(30);
        set_ratio(128, "R5"); run(140);
        set_ratio(127, "R5"); run(135);
        set_ratio(0, "R3");   run(6);
        set_ratio(200, "R3"); run(135);

        // mid-period change: old period must finish first
        set_ratio(9, "R7");   run(12);
        set_ratio(4, "R7");   run(3);
        set_ratio(6, "R7");   run(30);

        // packed words: low=3, high=5
        set_words((5 << 6) | 3, 0, "R10");        run(25);
        // edge flag set: no effect
        set_words((5 << 6) | 3, 16'h0080, "R10"); run(25);
        // zero fields mean 64 each
        set_words(0, 0, "R5");                    run(140);
        // bypass overrides fields
        set_words((9 << 6) | 4, 16'h0040, "R6");  run(10);
        set_words((1 << 6) | 2, 0, "R10");        run(12);
        set_ratio(10, "R10");                     run(25);

        comparing = 1'b0;
        finished  = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule